// File: doc/BRIEF.md
# Timestamped Cluster Sample Unpacker

This block turns a compressed capture record into a flat stream of 16-bit sample words. The record arrives as a stream of 16-bit words that are already assembled from little-endian byte pairs. It is organised in chunks of clusters. Each cluster opens with a timestamp word and carries a fixed number of event words. An event word holds one, two or four time-ordered samples, depending on the capture mode. The samples are interleaved bit by bit, so the block unpacks them. When the timestamp of a cluster jumps by more than the cluster covers, the gap is filled by repeating the most recently emitted sample before the cluster's own samples go out.

A run starts with a one-cycle `start_i` pulse. The pulse latches the mode, the number of chunks and an optional limit timestamp. The limit applies only to the final chunk, so that a partly written last chunk can be cut short. Input words are taken with a valid/ready handshake and samples are delivered with another. Backpressure on the output stalls all progress and loses nothing. When the final cluster has been fully handled, the block raises `done_o` for one cycle and returns to idle.

Top module: `ts_cluster_unpack`

## Requirements
- R1: After reset and before any start, `word_ready_o`, `smp_valid_o` and `done_o` are all low.
- R2: Each cluster is consumed as one timestamp word followed by EVENTS event words, and each chunk holds CLUSTERS clusters. Every non-dropped cluster yields exactly its padding plus EVENTS×S samples, in input order.
- R3: With `mode_i`=0 (S=1), each event word is emitted unchanged as one sample.
- R4: With `mode_i`=1 (S=2), an event yields two samples. Bit l (l<8) of sample k is event bit 2l+k, and bits 15:8 are zero.
- R5: With `mode_i`=2 or 3 (S=4), an event yields four samples. Bit l (l<4) of sample k is event bit 4l+k, and bits 15:4 are zero.
- R6: Let d be the timestamp minus the previous cluster's timestamp, modulo 2^16. If d exceeds EVENTS, the previously emitted sample is output (d−EVENTS)×S times before the cluster's samples. Otherwise no padding is output.
- R7: The first cluster of a run is never padded, as if the previous timestamp were one less than its own.
- R8: If `limit_i` is nonzero, then in the final chunk the first cluster whose timestamp is greater than the limit (unsigned) is dropped, and so is every later cluster. Dropped clusters are still consumed but emit nothing. Earlier chunks are never cut.
- R9: While `smp_valid_o` is high and `smp_ready_i` is low, `smp_o` and `smp_valid_o` hold. No input word is taken while a sample is pending.
- R10: After the final cluster of the final chunk is completed, `done_o` is high for exactly one cycle and the block is idle from that cycle on.
- R11: `mode_i`, `limit_i` and `num_chunks_i` are sampled only at `start_i`. A chunk count of zero runs one chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (taken while idle) |
| mode_i | input | 2 | Samples per event: 0→1, 1→2, 2/3→4 |
| limit_i | input | 16 | Final-chunk limit timestamp, 0 = none |
| num_chunks_i | input | CHUNK_W | Chunks in the run |
| word_i | input | 16 | Record word (timestamp or event) |
| word_valid_i | input | 1 | Record word valid |
| word_ready_o | output | 1 | Record word accepted |
| smp_o | output | 16 | Sample, zero-extended |
| smp_valid_o | output | 1 | Sample valid |
| smp_ready_i | input | 1 | Sample consumer ready |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the block with CLUSTERS=4 and EVENTS=3. Chunk boundaries, the final-chunk limit and the end of the run are then only a few dozen words away. This makes it cheap to sweep all four mode codes, one- and two-chunk runs, a zero chunk count and a limit that cuts part or all of the final chunk. The timestamp gaps are chosen so that small, equal and large jumps all occur, including a wrap through zero. Several valid/ready duty patterns stress stalls in the middle of padding and in the middle of an event.

// File: rtl/ts_unpack_pkg.sv
package ts_unpack_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TS,
    ST_PAD,
    ST_EVT,
    ST_SUB
  } st_e;

  // log2 of samples per event; code 3 aliases the four-sample mode
  function automatic logic [1:0] lg_spe(input logic [1:0] m);
    return (m == 2'd3) ? 2'd2 : m;
  endfunction
endpackage

// File: rtl/ts_unpack_deint.sv
module ts_unpack_deint #(
  parameter int SMP_W  = 16,
  parameter int MAX_LG = 2
) (
  input  logic [SMP_W-1:0] ev_i,
  input  logic [1:0]       lg_i,
  input  logic [1:0]       sub_i,
  output logic [SMP_W-1:0] smp_o
);
  localparam int N_MODES = MAX_LG + 1;

  logic [SMP_W-1:0] by_mode [N_MODES];

  for (genvar m = 0; m < N_MODES; m++) begin : g_mode
    localparam int S  = 1 << m;
    localparam int CH = SMP_W >> m;
    logic [SMP_W-1:0] cand [S];
    for (genvar k = 0; k < S; k++) begin : g_sub
      for (genvar l = 0; l < SMP_W; l++) begin : g_bit
        if (l < CH) begin : g_live
          assign cand[k][l] = ev_i[l*S+k];
        end else begin : g_zero
          assign cand[k][l] = 1'b0;
        end
      end
    end
    if (m == 0) begin : g_one
      assign by_mode[m] = cand[0];
    end else begin : g_many
      assign by_mode[m] = cand[sub_i[m-1:0]];
    end
  end

  always_comb begin
    smp_o = '0;
    for (int m = 0; m < N_MODES; m++) begin
      if (lg_i == 2'(m)) smp_o = by_mode[m];
    end
  end
endmodule

// File: rtl/ts_unpack_gap.sv
module ts_unpack_gap #(
  parameter int TS_W   = 16,
  parameter int EVENTS = 7,
  parameter int PAD_W  = TS_W + 2
) (
  input  logic [TS_W-1:0]  ts_i,
  input  logic [TS_W-1:0]  last_ts_i,
  input  logic             first_i,
  input  logic [1:0]       lg_i,
  output logic [PAD_W-1:0] pad_o
);
  logic [TS_W-1:0] diff;
  logic [TS_W-1:0] excess;

  always_comb begin
    diff   = first_i ? TS_W'(1) : ts_i - last_ts_i;
    excess = (diff > TS_W'(EVENTS)) ? diff - TS_W'(EVENTS) : '0;
    pad_o  = PAD_W'(excess) << lg_i;
  end
endmodule

// File: rtl/ts_cluster_unpack.sv
module ts_cluster_unpack
  import ts_unpack_pkg::*;
#(
  parameter int CLUSTERS = 64,
  parameter int EVENTS   = 7,
  parameter int CHUNK_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [1:0]         mode_i,
  input  logic [15:0]        limit_i,
  input  logic [CHUNK_W-1:0] num_chunks_i,
  input  logic [15:0]        word_i,
  input  logic               word_valid_i,
  output logic               word_ready_o,
  output logic [15:0]        smp_o,
  output logic               smp_valid_o,
  input  logic               smp_ready_i,
  output logic               done_o
);
  localparam int SMP_W  = 16;
  localparam int MAX_LG = 2;
  localparam int PAD_W  = SMP_W + MAX_LG;
  localparam int CL_W   = $clog2(CLUSTERS);
  localparam int EV_W   = $clog2(EVENTS);

  st_e                st_q;
  logic [1:0]         lg_q;
  logic [SMP_W-1:0]   limit_q;
  logic [CHUNK_W-1:0] nchunk_q, chunk_q;
  logic [CL_W-1:0]    clus_q;
  logic [EV_W-1:0]    evt_q;
  logic [1:0]         sub_q;
  logic [SMP_W-1:0]   last_ts_q;
  logic               first_q, drop_q, done_q;
  logic [PAD_W-1:0]   pad_q, pad_w;
  logic [SMP_W-1:0]   ev_q, last_smp_q, deint_w;

  logic [1:0]   spe_m1;
  logic [CHUNK_W:0] chunk_nx;
  logic final_chunk, drop_now, in_fire, out_fire, evt_done, evt_last, clus_last;

  ts_unpack_deint #(.SMP_W(SMP_W), .MAX_LG(MAX_LG)) u_deint (
    .ev_i (ev_q),
    .lg_i (lg_q),
    .sub_i(sub_q),
    .smp_o(deint_w)
  );

  ts_unpack_gap #(.TS_W(SMP_W), .EVENTS(EVENTS), .PAD_W(PAD_W)) u_gap (
    .ts_i     (word_i),
    .last_ts_i(last_ts_q),
    .first_i  (first_q),
    .lg_i     (lg_q),
    .pad_o    (pad_w)
  );

  always_comb begin
    case (lg_q)
      2'd0:    spe_m1 = 2'd0;
      2'd1:    spe_m1 = 2'd1;
      default: spe_m1 = 2'd3;
    endcase
  end

  assign word_ready_o = (st_q == ST_TS) || (st_q == ST_EVT);
  assign smp_valid_o  = (st_q == ST_PAD) || (st_q == ST_SUB);
  assign smp_o        = (st_q == ST_PAD) ? last_smp_q : deint_w;
  assign done_o       = done_q;

  assign in_fire     = word_valid_i && word_ready_o;
  assign out_fire    = smp_valid_o && smp_ready_i;
  assign chunk_nx    = {1'b0, chunk_q} + (CHUNK_W+1)'(1);
  assign final_chunk = chunk_nx >= {1'b0, nchunk_q};
  assign drop_now    = final_chunk && (limit_q != '0) && (word_i > limit_q);
  assign evt_last    = evt_q == EV_W'(EVENTS - 1);
  assign clus_last   = clus_q == CL_W'(CLUSTERS - 1);
  assign evt_done    = ((st_q == ST_EVT) && in_fire && drop_q) ||
                       ((st_q == ST_SUB) && out_fire && (sub_q == spe_m1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      lg_q       <= '0;
      limit_q    <= '0;
      nchunk_q   <= '0;
      chunk_q    <= '0;
      clus_q     <= '0;
      evt_q      <= '0;
      sub_q      <= '0;
      last_ts_q  <= '0;
      first_q    <= 1'b0;
      drop_q     <= 1'b0;
      done_q     <= 1'b0;
      pad_q      <= '0;
      ev_q       <= '0;
      last_smp_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          lg_q       <= lg_spe(mode_i);
          limit_q    <= limit_i;
          nchunk_q   <= num_chunks_i;
          chunk_q    <= '0;
          clus_q     <= '0;
          first_q    <= 1'b1;
          drop_q     <= 1'b0;
          last_smp_q <= '0;
          st_q       <= ST_TS;
        end
        ST_TS: if (in_fire) begin
          evt_q     <= '0;
          first_q   <= 1'b0;
          last_ts_q <= word_i;
          if (drop_q || drop_now) begin
            drop_q <= 1'b1;
            st_q   <= ST_EVT;
          end else if (pad_w != '0) begin
            pad_q <= pad_w;
            st_q  <= ST_PAD;
          end else begin
            st_q <= ST_EVT;
          end
        end
        ST_PAD: if (out_fire) begin
          pad_q <= pad_q - PAD_W'(1);
          if (pad_q == PAD_W'(1)) st_q <= ST_EVT;
        end
        ST_EVT: if (in_fire && !drop_q) begin
          ev_q  <= word_i;
          sub_q <= '0;
          st_q  <= ST_SUB;
        end
        ST_SUB: if (out_fire) begin
          last_smp_q <= smp_o;
          if (sub_q != spe_m1) sub_q <= sub_q + 2'd1;
        end
        default: st_q <= ST_IDLE;
      endcase

      if (evt_done) begin
        if (!evt_last) begin
          evt_q <= evt_q + EV_W'(1);
          st_q  <= ST_EVT;
        end else if (!clus_last) begin
          clus_q <= clus_q + CL_W'(1);
          st_q   <= ST_TS;
        end else begin
          clus_q <= '0;
          drop_q <= 1'b0;
          if (final_chunk) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            chunk_q <= chunk_q + CHUNK_W'(1);
            st_q    <= ST_TS;
          end
        end
      end
    end
  end

  // R9: a stalled sample is held
  a_r9_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o && !smp_ready_i |=> smp_valid_o && $stable(smp_o));

  // R9: input and output sides never open together
  a_r9_one_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(word_ready_o && smp_valid_o));

  // R10: done lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10: idle once done
  a_r10_quiet_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !word_ready_o && !smp_valid_o);

  // R4: two-sample mode keeps upper byte clear
  a_r4_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o && (lg_q == 2'd1) |-> smp_o[15:8] == 8'h00);

  // R5: four-sample mode keeps upper bits clear
  a_r5_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o && (lg_q == 2'd2) |-> smp_o[15:4] == 12'h000);
endmodule

// File: tb/ts_cluster_unpack_bench.sv
module ts_cluster_unpack_bench;
  localparam int CL  = 4;
  localparam int EV  = 3;
  localparam int CHW = 16;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           start_i = 1'b0;
  logic [1:0]     mode_i = '0;
  logic [15:0]    limit_i = '0;
  logic [CHW-1:0] num_chunks_i = '0;
  logic [15:0]    word_i = '0;
  logic           word_valid_i = 1'b0;
  logic           word_ready_o;
  logic [15:0]    smp_o;
  logic           smp_valid_o;
  logic           smp_ready_i = 1'b0;
  logic           done_o;

  ts_cluster_unpack #(.CLUSTERS(CL), .EVENTS(EV), .CHUNK_W(CHW)) u_ts_cluster_unpack (
    .clk_i, .rst_ni, .start_i, .mode_i, .limit_i, .num_chunks_i,
    .word_i, .word_valid_i, .word_ready_o,
    .smp_o, .smp_valid_o, .smp_ready_i, .done_o
  );

  always #5 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int done_cnt = 0;

  logic [15:0] words [2048];
  int          n_words;
  logic [15:0] exp_v [1024];
  string       exp_tag [1024];
  int          n_exp;
  logic [15:0] lim_r;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    forever begin
      @(negedge clk_i);
      cyc++;
      if (done_o) done_cnt++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        summary();
        $finish;
      end
    end
  end

  function automatic int gap_of(int c, int sel);
    case ((c + sel) % 5)
      0: return 2;
      1: return EV;
      2: return 8;
      3: return 11;
      default: return 5;
    endcase
  endfunction

  function automatic logic [15:0] sub_of(logic [15:0] ev, int s, int k);
    logic [15:0] v = '0;
    for (int l = 0; l < 16 / s; l++) v[l] = ev[l*s + k];
    return v;
  endfunction

  task automatic build(input int mode, input int nch_in, input int lim_idx,
                       input logic [15:0] ts0, input int sel);
    int nch = (nch_in == 0) ? 1 : nch_in;
    int s = 1 << ((mode == 3) ? 2 : mode);
    int total = nch * CL;
    logic [15:0] tsv [64];
    logic [15:0] last, last_ts, ev;
    logic [15:0] d;
    bit drop;
    string mtag;
    mtag = (s == 1) ? "R3" : (s == 2) ? "R4" : "R5";
    n_words = 0;
    n_exp = 0;
    for (int c = 0; c < total; c++)
      tsv[c] = (c == 0) ? ts0 : 16'(tsv[c-1] + 16'(gap_of(c, sel)));
    lim_r = (lim_idx < 0) ? 16'h0 : tsv[lim_idx];
    for (int c = 0; c < total; c++) begin
      words[n_words++] = tsv[c];
      for (int e = 0; e < EV; e++)
        words[n_words++] = 16'(c * 40503 + e * 9973 + mode * 7 + sel * 131 + 1);
    end
    last = '0;
    last_ts = 16'(ts0 - 16'd1);
    drop = 1'b0;
    for (int c = 0; c < total; c++) begin
      if (c % CL == 0) drop = 1'b0;
      if ((c / CL == nch - 1) && lim_r != 0 && tsv[c] > lim_r) drop = 1'b1;
      if (!drop) begin
        d = 16'(tsv[c] - last_ts);
        last_ts = tsv[c];
        if (int'(d) > EV)
          for (int p = 0; p < (int'(d) - EV) * s; p++) begin
            exp_v[n_exp] = last; exp_tag[n_exp] = "R6"; n_exp++;
          end
        for (int e = 0; e < EV; e++) begin
          ev = words[c * (EV + 1) + 1 + e];
          for (int k = 0; k < s; k++) begin
            last = sub_of(ev, s, k);
            exp_v[n_exp] = last;
            exp_tag[n_exp] = (c == 0) ? "R7" : mtag;
            n_exp++;
          end
        end
      end
    end
  endtask

  function automatic bit vpat(int pat, int c);
    case (pat)
      0: return 1'b1;
      1: return (c % 4) != 1;
      default: return (c % 3) != 2;
    endcase
  endfunction

  function automatic bit rpat(int pat, int c);
    case (pat)
      0: return 1'b1;
      1: return (c % 3) != 0;
      default: return (c % 5) < 2;
    endcase
  endfunction

  task automatic run(input int mode, input int nch, input int lim_idx,
                     input logic [15:0] ts0, input int sel, input int pat,
                     input string ctag);
    int d0;
    int got;
    build(mode, nch, lim_idx, ts0, sel);
    @(negedge clk_i);
    mode_i = 2'(mode);
    limit_i = lim_r;
    num_chunks_i = CHW'(nch);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    // R11: scramble the run settings after start
    mode_i = ~2'(mode);
    limit_i = 16'h0001;
    num_chunks_i = CHW'(7);
    d0 = done_cnt;
    got = 0;
    fork
      begin : drv
        int wi = 0;
        bit pend = 1'b0;
        while (wi < n_words) begin
          @(negedge clk_i);
          if (pend) wi++;
          pend = 1'b0;
          if (wi < n_words) begin
            word_valid_i = vpat(pat, cyc);
            word_i = words[wi];
          end else begin
            word_valid_i = 1'b0;
          end
          #1;
          pend = word_valid_i && word_ready_o;
        end
      end
      begin : con
        int ri = 0;
        bit pend = 1'b0;
        bit stall = 1'b0;
        logic [15:0] held = '0;
        while (ri < n_exp) begin
          @(negedge clk_i);
          if (pend) ri++;
          pend = 1'b0;
          if (stall)
            chk(smp_valid_o && smp_o == held, "R9", int'(smp_o), int'(held));
          smp_ready_i = (ri < n_exp) ? rpat(pat, cyc + 1) : 1'b0;
          #1;
          stall = smp_valid_o && !smp_ready_i;
          held = smp_o;
          if (smp_valid_o && smp_ready_i && ri < n_exp) begin
            chk(smp_o == exp_v[ri], exp_tag[ri], int'(smp_o), int'(exp_v[ri]));
            pend = 1'b1;
          end
        end
        got = ri;
      end
    join
    smp_ready_i = 1'b0;
    repeat (4) @(negedge clk_i);
    #1;
    chk(got == n_exp, ctag, got, n_exp);
    chk(done_cnt - d0 == 1, "R10", done_cnt - d0, 1);
    chk(!word_ready_o && !smp_valid_o, "R10", {word_ready_o, smp_valid_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk(!word_ready_o && !smp_valid_o && !done_o, "R1",
        {word_ready_o, smp_valid_o, done_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    #1;
    chk(!word_ready_o && !smp_valid_o && !done_o, "R1",
        {word_ready_o, smp_valid_o, done_o}, 0);

    run(0, 1, -1, 16'd100, 0, 0, "R2");
    run(1, 2, -1, 16'd200, 1, 1, "R2");
    run(2, 2, -1, 16'd300, 2, 2, "R2");
    run(3, 1, -1, 16'd400, 3, 1, "R5");
    run(0, 2, -1, 16'd500, 4, 2, "R2");
    run(1, 2, CL + 1, 16'd600, 0, 1, "R8");
    run(2, 2, 1, 16'd700, 2, 2, "R8");
    run(0, 2, 2 * CL - 1, 16'd800, 1, 0, "R8");
    run(0, 1, -1, 16'hFFF0, 2, 1, "R6");
    run(1, 0, -1, 16'd900, 3, 2, "R11");

    summary();
    $finish;
  end
endmodule